// File: doc/BRIEF.md
# I/O Window Chip-Select Decoder with Wait-State Insertion

This block sits between a processor's bus sequencer and its peripheral I/O space. It divides the low end of a 16-bit I/O address space into 256-byte windows. For each window it drives an active-low select line to an external peripheral. One window in that range is kept for an on-chip network MAC and drives no pin. The top 256 bytes of the space select the internal register block. The selects appear in the same cycle as the address phase of an I/O cycle. They hold until the strobe is released.

Each external window has its own 4-bit wait count. At the start of a cycle a down-counter loads the count that belongs to the decoded window, and ready to the sequencer stays low until that counter is empty. The four lower windows come out of reset with the slowest setting. The two upper windows come out of reset with a short setting, and a strap input can freeze that short setting against writes. Internal targets and unmapped addresses add no wait states.

Top module: `periph_sel_wait`

## Requirements
- R1: With the strobe high, address high byte 0x00, 0x01, 0x02 or 0x03 drives `ext_sel_n` bit 0, 1, 2 or 3 low. High byte 0x05 drives bit 4 low and 0x06 drives bit 5 low. All other bits stay high.
- R2: High byte 0x04 raises `mac_sel` and leaves every `ext_sel_n` bit high.
- R3: High byte 0xFF raises `reg_sel` and leaves every `ext_sel_n` bit high.
- R4: Any other high byte asserts no select and inserts no wait states.
- R5: Selects are decoded from `io_addr` in the cycle where `io_req` and `addr_phase` are both high. They hold unchanged for the rest of the cycle even if the address bus changes. At most one select is active at any time, and none is active while `io_req` is low.
- R6: `rdy` is low in the address-phase cycle. It then stays low for exactly W data-phase cycles, where W is the decoded window's wait count (0 for internal and unmapped targets), and it stays high until `io_req` falls.
- R7: After reset the wait count is 15 for windows 0–3 and 3 for windows 5–6.
- R8: A clock edge with `cfg_we` high and `cfg_idx` equal to a window number (0–3, 5, 6) loads `cfg_wdata` as that window's wait count. The new count applies to cycles that start after that edge.
- R9: While `upper_lock` is high, writes to windows 5 and 6 are ignored. While it is low they are accepted. Writes with `cfg_idx` 4 or 7 are always ignored.
- R10: `rdy` is low whenever `io_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address from the bus |
| io_req | input | 1 | I/O strobe; high for the whole bus cycle |
| addr_phase | input | 1 | High in the address-phase cycle that opens a bus cycle |
| upper_lock | input | 1 | Freezes the wait counts of windows 5 and 6 |
| cfg_we | input | 1 | Wait-count write enable |
| cfg_idx | input | 3 | Window number to write |
| cfg_wdata | input | 4 | Wait count to write |
| ext_sel_n | output | 6 | Active-low external selects (windows 0,1,2,3,5,6) |
| mac_sel | output | 1 | Internal MAC window select |
| reg_sel | output | 1 | Internal register block select |
| rdy | output | 1 | Ready to the bus sequencer |

## Verification
The checker watches several properties on every cycle. It confirms that at most one select is active and that everything is idle while the strobe is low. It confirms that selects do not move during the data phase and that ready is never raised in the address phase. It confirms that ready stays up once raised, and that a run of not-ready cycles never exceeds the largest wait count. The exact wait count for each window cannot be checked that way: the reset defaults, register writes, the upper-window lock and the decode of each address window can only be shown by the bench's scenarios. The bench compares measured ready latency and select patterns against its own model of the wait-count registers.

// File: rtl/psel_pkg.sv
package psel_pkg;
   // number of 256-byte windows at the bottom of I/O space, slot reserved for the MAC
   localparam int unsigned NSLOT    = 7;
   localparam int unsigned MAC_SLOT = 4;
   localparam int unsigned IDX_W    = $clog2(NSLOT + 1);

   typedef struct packed {
      logic [NSLOT-1:0] slot;
      logic             mac;
      logic             regs;
   } psel_hit_t;
endpackage

// File: rtl/psel_decode.sv
module psel_decode
   import psel_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned WIN_W  = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output psel_hit_t         hit
);
   localparam int unsigned UP_W = ADDR_W - WIN_W;

   if (ADDR_W <= WIN_W) begin : g_bad_win
      $error("psel_decode: ADDR_W must exceed WIN_W");
   end
   if (UP_W < IDX_W) begin : g_bad_up
      $error("psel_decode: too few window bits for the slot count");
   end

   logic [UP_W-1:0] upper;
   assign upper = addr[ADDR_W-1:WIN_W];

   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      if (i == MAC_SLOT) begin : g_mac
         assign hit.slot[i] = 1'b0;
      end else begin : g_ext
         assign hit.slot[i] = (upper == UP_W'(i));
      end
   end

   assign hit.mac  = (upper == UP_W'(MAC_SLOT));
   assign hit.regs = &upper;
endmodule

// File: rtl/psel_wait_regs.sv
module psel_wait_regs
   import psel_pkg::*;
#(
   parameter int unsigned WAIT_W  = 4,
   parameter int unsigned LO_DFLT = 15,
   parameter int unsigned HI_DFLT = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         we,
   input  logic [IDX_W-1:0]             idx,
   input  logic [WAIT_W-1:0]            wdata,
   input  logic                         lock_hi,
   output logic [NSLOT-1:0][WAIT_W-1:0] waits
);
   for (genvar i = 0; i < NSLOT; i++) begin : g_reg
      if (i == MAC_SLOT) begin : g_fixed
         assign waits[i] = '0;
      end else begin : g_prog
         localparam int unsigned DFLT     = (i < MAC_SLOT) ? LO_DFLT : HI_DFLT;
         localparam bit          LOCKABLE = (i > MAC_SLOT);
         logic [WAIT_W-1:0] w_q;
         logic              hit_wr;

         assign hit_wr = we && (idx == IDX_W'(i)) && !(LOCKABLE && lock_hi);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      w_q <= WAIT_W'(DFLT);
            else if (hit_wr) w_q <= wdata;
         end
         assign waits[i] = w_q;
      end
   end
endmodule

// File: rtl/psel_wait_ctr.sv
module psel_wait_ctr #(
   parameter int unsigned WAIT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              live,
   input  logic              phase,
   input  logic [WAIT_W-1:0] load,
   output logic              rdy
);
   logic [WAIT_W-1:0] cnt_q;
   logic              busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (start) begin
         cnt_q  <= load;
         busy_q <= 1'b1;
      end else if (!live) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (busy_q && cnt_q != '0) begin
         cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign rdy = busy_q && live && !phase && (cnt_q == '0);
endmodule

// File: rtl/periph_sel_wait.sv
module periph_sel_wait
   import psel_pkg::*;
#(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned WIN_W   = 8,
   parameter int unsigned WAIT_W  = 4,
   parameter int unsigned LO_DFLT = 15,
   parameter int unsigned HI_DFLT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_req,
   input  logic              addr_phase,
   input  logic              upper_lock,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [WAIT_W-1:0] cfg_wdata,
   output logic [NSLOT-2:0]  ext_sel_n,
   output logic              mac_sel,
   output logic              reg_sel,
   output logic              rdy
);
   localparam int unsigned NEXT = NSLOT - 1;

   if (LO_DFLT >= (1 << WAIT_W) || HI_DFLT >= (1 << WAIT_W)) begin : g_bad_dflt
      $error("periph_sel_wait: default wait count exceeds WAIT_W");
   end

   psel_hit_t                    dec, held_q, cur;
   logic [NSLOT-1:0][WAIT_W-1:0] waits;
   logic [WAIT_W-1:0]            load;
   logic                         start;

   assign start = io_req && addr_phase;

   psel_decode #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_dec (
      .addr (io_addr),
      .hit  (dec)
   );

   psel_wait_regs #(.WAIT_W(WAIT_W), .LO_DFLT(LO_DFLT), .HI_DFLT(HI_DFLT)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .idx     (cfg_idx),
      .wdata   (cfg_wdata),
      .lock_hi (upper_lock),
      .waits   (waits)
   );

   always_comb begin
      load = '0;
      for (int i = 0; i < NSLOT; i++) begin
         if (dec.slot[i]) load = waits[i];
      end
   end

   psel_wait_ctr #(.WAIT_W(WAIT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .live  (io_req),
      .phase (addr_phase),
      .load  (load),
      .rdy   (rdy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       held_q <= '0;
      else if (start)   held_q <= dec;
      else if (!io_req) held_q <= '0;
   end

   assign cur = start ? dec : (io_req ? held_q : '0);

   for (genvar e = 0; e < NEXT; e++) begin : g_pin
      localparam int unsigned S = (e < MAC_SLOT) ? e : e + 1;
      assign ext_sel_n[e] = ~cur.slot[S];
   end

   assign mac_sel = cur.mac;
   assign reg_sel = cur.regs;
endmodule

// File: rtl/psel_chk.sv
module psel_chk #(
   parameter int unsigned WAIT_W = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       io_req,
   input logic       addr_phase,
   input logic [5:0] ext_sel_n,
   input logic       mac_sel,
   input logic       reg_sel,
   input logic       rdy
);
   localparam int unsigned MAXW = (1 << WAIT_W) - 1;

   logic [WAIT_W:0] gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              gap_q <= '0;
      else if (io_req && !addr_phase && !rdy)  gap_q <= gap_q + 1'b1;
      else                                     gap_q <= '0;
   end

   // R5: never more than one target selected
   a_r5_one_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({~ext_sel_n, mac_sel, reg_sel}));

   // R5: all selects idle without the strobe
   a_r5_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      !io_req |-> (&ext_sel_n && !mac_sel && !reg_sel));

   // R5: selects hold through the data phase
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (io_req && !addr_phase && $past(io_req)) |->
         ($stable(ext_sel_n) && $stable(mac_sel) && $stable(reg_sel)));

   // R6 / R10: no ready in address phase or without the strobe
   a_r6_no_rdy_early: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_phase || !io_req) |-> !rdy);

   // R6: ready stays up until the strobe falls
   a_r6_rdy_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (io_req && !addr_phase && $past(rdy)) |-> rdy);

   // R6: the not-ready run never passes the largest wait count
   a_r6_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (io_req && !addr_phase && !rdy) |-> (gap_q < (WAIT_W+1)'(MAXW)));
endmodule

bind periph_sel_wait psel_chk #(.WAIT_W(WAIT_W)) u_psel_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .io_req     (io_req),
   .addr_phase (addr_phase),
   .ext_sel_n  (ext_sel_n),
   .mac_sel    (mac_sel),
   .reg_sel    (reg_sel),
   .rdy        (rdy)
);

// File: tb/periph_sel_wait_tb_top.sv
module periph_sel_wait_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] io_addr;
   logic        io_req, addr_phase, upper_lock, cfg_we;
   logic [2:0]  cfg_idx;
   logic [3:0]  cfg_wdata;
   logic [5:0]  ext_sel_n;
   logic        mac_sel, reg_sel, rdy;

   int n_chk = 0;
   int n_bad = 0;
   logic [3:0] mw [0:6];

   always #5 clk = ~clk;

   periph_sel_wait dut_i (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_req(io_req),
      .addr_phase(addr_phase), .upper_lock(upper_lock), .cfg_we(cfg_we),
      .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .ext_sel_n(ext_sel_n),
      .mac_sel(mac_sel), .reg_sel(reg_sel), .rdy(rdy)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   function automatic logic [5:0] exp_ext(input logic [15:0] a);
      case (a[15:8])
         8'h00, 8'h01, 8'h02, 8'h03: return ~(6'b1 << a[9:8]);
         8'h05: return 6'b101111;
         8'h06: return 6'b011111;
         default: return 6'b111111;
      endcase
   endfunction

   function automatic int exp_wait(input logic [15:0] a);
      if (a[15:8] < 8'd7 && a[15:8] != 8'd4) return int'(mw[a[10:8]]);
      return 0;
   endfunction

   function automatic string tag_of(input logic [15:0] a);
      if (a[15:8] < 8'd7 && a[15:8] != 8'd4) return "R1";
      if (a[15:8] == 8'h04) return "R2";
      if (a[15:8] == 8'hFF) return "R3";
      return "R4";
   endfunction

   task automatic run_cycle(input logic [15:0] a);
      string t;
      int    n;
      logic [5:0] e;
      t = tag_of(a);
      e = exp_ext(a);
      @(negedge clk);
      io_req = 1'b1; addr_phase = 1'b1; io_addr = a;
      #2;
      chk(ext_sel_n == e, {t, " R5 select in address phase"}, ext_sel_n, e);
      chk(mac_sel == (a[15:8] == 8'h04), {t, " mac_sel"}, mac_sel, a[15:8] == 8'h04);
      chk(reg_sel == (a[15:8] == 8'hFF), {t, " reg_sel"}, reg_sel, a[15:8] == 8'hFF);
      chk(!rdy, "R6 rdy low in address phase", rdy, 0);
      @(negedge clk);
      addr_phase = 1'b0; io_addr = 16'($urandom);
      n = 0;
      forever begin
         #2;
         chk(ext_sel_n == e, "R5 select held in data phase", ext_sel_n, e);
         if (rdy || n > 40) break;
         n++;
         @(negedge clk);
      end
      chk(n == exp_wait(a), {t, " R6 wait count"}, n, exp_wait(a));
      @(negedge clk);
      #2;
      chk(rdy, "R6 rdy held until strobe drops", rdy, 1);
      @(negedge clk);
      io_req = 1'b0;
      #2;
      chk(!rdy, "R10 rdy low without strobe", rdy, 0);
      chk(ext_sel_n == 6'h3F && !mac_sel && !reg_sel, "R5 idle without strobe",
          {ext_sel_n, mac_sel, reg_sel}, 8'hFC);
   endtask

   task automatic cfg_write(input logic [2:0] idx, input logic [3:0] val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = val;
      @(negedge clk);
      cfg_we = 1'b0;
      if (idx < 3'd4 || ((idx == 3'd5 || idx == 3'd6) && !upper_lock)) mw[idx] = val;
   endtask

   initial begin
      #(100000 * 10);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      report();
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 7; i++) mw[i] = (i < 4) ? 4'd15 : ((i == 4) ? 4'd0 : 4'd3);
      rst_n = 1'b0; io_addr = '0; io_req = 1'b0; addr_phase = 1'b0;
      upper_lock = 1'b1; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
      repeat (3) @(negedge clk);
      #2;
      chk(ext_sel_n == 6'h3F && !mac_sel && !reg_sel && !rdy, "R10 reset state idle",
          {ext_sel_n, mac_sel, reg_sel, rdy}, 9'h1F8);
      rst_n = 1'b1;

      // R7 reset defaults
      run_cycle(16'h0000);
      run_cycle(16'h03FF);
      run_cycle(16'h0500);
      run_cycle(16'h06FF);
      // R2 R3 R4 window edges
      run_cycle(16'h0400);
      run_cycle(16'h04FF);
      run_cycle(16'hFF00);
      run_cycle(16'hFFFF);
      run_cycle(16'h0700);
      run_cycle(16'hFEFF);
      run_cycle(16'h00FF);
      run_cycle(16'h0100);

      // R5 address phase without the strobe selects nothing
      @(negedge clk);
      addr_phase = 1'b1; io_addr = 16'h0100;
      #2;
      chk(ext_sel_n == 6'h3F && !rdy, "R5 no select without strobe", ext_sel_n, 6'h3F);
      @(negedge clk);
      addr_phase = 1'b0;

      // R8 writes
      cfg_write(3'd0, 4'd2);  run_cycle(16'h0010);
      cfg_write(3'd1, 4'd0);  run_cycle(16'h0180);
      // R9 locked upper group, MAC slot and idx 7 ignored
      cfg_write(3'd5, 4'd9);  run_cycle(16'h0500);
      cfg_write(3'd4, 4'd7);  run_cycle(16'h0420);
      cfg_write(3'd7, 4'd1);  run_cycle(16'h0200);
      upper_lock = 1'b0;
      cfg_write(3'd6, 4'd11); run_cycle(16'h0601);
      cfg_write(3'd5, 4'd0);  run_cycle(16'h05AA);

      // constrained random
      for (int k = 0; k < 250; k++) begin
         logic [15:0] a;
         int sel;
         if ($urandom_range(0, 3) == 0) cfg_write(3'($urandom_range(0, 7)), 4'($urandom));
         if ($urandom_range(0, 7) == 0) upper_lock = ~upper_lock;
         sel = $urandom_range(0, 9);
         a[7:0] = 8'($urandom);
         if (sel < 7)       a[15:8] = 8'(sel);
         else if (sel == 7) a[15:8] = 8'hFF;
         else               a[15:8] = 8'($urandom);
         run_cycle(a);
      end
      report();
   end
endmodule